// File: doc/BRIEF.md
# Programmable Wait-State Bus Sequencer

This block times processor bus cycles to memory and I/O targets that are slower than the processor. A one-clock start request arrives with three qualifiers: whether the target is memory or I/O, whether the cycle is a read or a write, and whether the memory target is RAM protected by error correction. The block then drives the matching active-low strobe for the length of the cycle. It ends the cycle with a one-clock active-low ready to the CPU.

Memory and I/O each have their own two-bit wait-count setting. The block takes the setting for the addressed class when the cycle starts. A RAM access gets one more wait state so that the error-correction logic has time to finish. A start that arrives while a cycle is already running is dropped. Address decoding and clock generation are handled elsewhere.

Top module: `ws_seq`

## Requirements
- R1: A memory access with memory wait setting M (0 to 3) and the RAM qualifier low takes M+1 active cycles. Ready is low only in the last of them.
- R2: An I/O access uses the I/O wait setting N (0 to 3) and ignores the memory setting. It takes N+1 active cycles.
- R3: When the RAM qualifier is high on a memory access, one extra wait is added, for reads and for writes, giving M+2 active cycles. On an I/O access the RAM qualifier has no effect.
- R4: During the active cycles, the active strobe is chosen by the access type. A memory read drives `mem_rd_no` low. A memory write drives `mem_wr_no` low. An I/O write drives `io_wr_no` low. An I/O read drives none of them. At most one strobe is low at any time.
- R5: `cycle_start_o` is high for exactly one clock, in the first active cycle. That cycle follows the clock edge at which the start was accepted.
- R6: A strobe is low from the first active cycle through the ready cycle. All strobes are high in the following cycle.
- R7: `rdy_no` is low for exactly one clock per accepted cycle.
- R8: A start that arrives during an active cycle is ignored. The running cycle keeps its length and strobe, and no new cycle follows.
- R9: The wait settings, access type and RAM qualifier are sampled at the accepted start. Changes to these inputs during the cycle have no effect.
- R10: While `rst_ni` is low, the block is idle: every strobe, `rdy_no` and `cycle_start_o` is inactive. After release, the block accepts a new start normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Cycle start request, sampled at a rising edge |
| is_mem_i | input | 1 | 1 = memory target, 0 = I/O target |
| wr_i | input | 1 | 1 = write, 0 = read |
| ram_sel_i | input | 1 | Memory target is error-corrected RAM |
| mem_ws_i | input | 2 | Memory wait states (0 to 3) |
| io_ws_i | input | 2 | I/O wait states (0 to 3) |
| cycle_start_o | output | 1 | High in the first active cycle |
| mem_rd_no | output | 1 | Memory read strobe, active low |
| mem_wr_no | output | 1 | Memory write strobe, active low |
| io_wr_no | output | 1 | I/O write strobe, active low |
| rdy_no | output | 1 | CPU ready, active low, one clock |

## Verification
Take the start as sampled at rising edge E0, and let W be the total wait count. Strobes and `cycle_start_o` become valid just after E0. `rdy_no` goes low W edges later, and the outputs return to idle one edge after that. The bench drives inputs and samples outputs on falling edges, so the first active cycle is the first falling edge after E0. It checks every output at each falling edge through the cycle, and once more at the idle edge that follows. Reset is asynchronous, so its effect is checked shortly after `rst_ni` falls, without waiting for a clock edge.

// File: rtl/ws_seq_pkg.sv
package ws_seq_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_MEMRD = 2'd1,
    ACC_MEMWR = 2'd2,
    ACC_IOWR  = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/ws_select.sv
module ws_select #(
  parameter int WS_W  = 2,
  parameter int CNT_W = WS_W + 1
) (
  input  logic             is_mem_i,
  input  logic             wr_i,
  input  logic             ram_sel_i,
  input  logic [WS_W-1:0]  mem_ws_i,
  input  logic [WS_W-1:0]  io_ws_i,
  output logic [CNT_W-1:0] waits_o,
  output ws_seq_pkg::acc_kind_e kind_o
);
  import ws_seq_pkg::*;

  logic [WS_W-1:0] base_ws;
  logic            ecc_extra;

  always_comb begin
    base_ws   = is_mem_i ? mem_ws_i : io_ws_i;
    // extra wait only for error-corrected RAM
    ecc_extra = is_mem_i & ram_sel_i;
    waits_o   = CNT_W'(base_ws) + CNT_W'(ecc_extra);
    if (is_mem_i)  kind_o = wr_i ? ACC_MEMWR : ACC_MEMRD;
    else if (wr_i) kind_o = ACC_IOWR;
    else           kind_o = ACC_NONE;
  end
endmodule

// File: rtl/ws_counter.sv
module ws_counter #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] waits_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             first_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, first_q;

  assign accept_o = start_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      first_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      first_q <= accept_o;
      if (accept_o) begin
        busy_q <= 1'b1;
        cnt_q  <= waits_i;
      end else if (busy_q) begin
        if (cnt_q == '0) busy_q <= 1'b0;
        else             cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  assign busy_o  = busy_q;
  assign first_o = first_q;
  assign last_o  = busy_q & (cnt_q == '0);

  // R8: start during a cycle does not reload the counter
  a_r8_busy_ignores_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));

  // R5: first cycle follows an accepted start
  a_r5_first_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> (first_q && busy_q));

  // R7: ready-cycle ends the cycle
  a_r7_last_then_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !busy_q);
endmodule

// File: rtl/ws_strobe_gen.sv
module ws_strobe_gen (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  accept_i,
  input  ws_seq_pkg::acc_kind_e kind_i,
  input  logic                  busy_i,
  output logic                  mem_rd_no,
  output logic                  mem_wr_no,
  output logic                  io_wr_no
);
  import ws_seq_pkg::*;

  acc_kind_e kind_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       kind_q <= ACC_NONE;
    else if (accept_i) kind_q <= kind_i;
  end

  assign mem_rd_no = ~(busy_i && kind_q == ACC_MEMRD);
  assign mem_wr_no = ~(busy_i && kind_q == ACC_MEMWR);
  assign io_wr_no  = ~(busy_i && kind_q == ACC_IOWR);

  // R4: never more than one strobe
  a_r4_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({~mem_rd_no, ~mem_wr_no, ~io_wr_no}));
endmodule

// File: rtl/ws_seq.sv
module ws_seq #(
  parameter int WS_W  = 2,
  localparam int CNT_W = WS_W + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            is_mem_i,
  input  logic            wr_i,
  input  logic            ram_sel_i,
  input  logic [WS_W-1:0] mem_ws_i,
  input  logic [WS_W-1:0] io_ws_i,
  output logic            cycle_start_o,
  output logic            mem_rd_no,
  output logic            mem_wr_no,
  output logic            io_wr_no,
  output logic            rdy_no
);
  import ws_seq_pkg::*;

  logic [CNT_W-1:0] waits;
  acc_kind_e        kind;
  logic             accept, busy, first, last;

  ws_select #(.WS_W(WS_W), .CNT_W(CNT_W)) u_sel (
    .is_mem_i (is_mem_i),
    .wr_i     (wr_i),
    .ram_sel_i(ram_sel_i),
    .mem_ws_i (mem_ws_i),
    .io_ws_i  (io_ws_i),
    .waits_o  (waits),
    .kind_o   (kind)
  );

  ws_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .waits_i (waits),
    .accept_o(accept),
    .busy_o  (busy),
    .first_o (first),
    .last_o  (last)
  );

  ws_strobe_gen u_stb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .kind_i   (kind),
    .busy_i   (busy),
    .mem_rd_no(mem_rd_no),
    .mem_wr_no(mem_wr_no),
    .io_wr_no (io_wr_no)
  );

  assign cycle_start_o = first;
  assign rdy_no        = ~last;

  // R7: ready lasts one clock
  a_r7_rdy_one_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_no |=> rdy_no);

  // R6: strobe held until ready
  a_r6_rd_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_rd_no && rdy_no) |=> !mem_rd_no);
  a_r6_wr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_wr_no && rdy_no) |=> !mem_wr_no);
  a_r6_io_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!io_wr_no && rdy_no) |=> !io_wr_no);

  // R5: start pulse is one clock wide
  a_r5_start_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_start_o |=> !cycle_start_o);

  // R6: strobes release after ready
  a_r6_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_no |=> (mem_rd_no && mem_wr_no && io_wr_no));
endmodule

// File: tb/ws_seq_test.sv
module ws_seq_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0, is_mem_i = 1'b0, wr_i = 1'b0, ram_sel_i = 1'b0;
  logic [1:0] mem_ws_i = 2'd0, io_ws_i = 2'd0;
  logic       cycle_start_o, mem_rd_no, mem_wr_no, io_wr_no, rdy_no;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #2.5 clk_i = ~clk_i;

  ws_seq uut (.*);

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_stb(logic mem, logic wr);
    if (mem) return wr ? 3'b101 : 3'b011;
    return wr ? 3'b110 : 3'b111;
  endfunction

  // {mem_rd_no, mem_wr_no, io_wr_no}
  task automatic run_cycle(string req, logic mem, logic wr, logic ram,
                           logic [1:0] mws, logic [1:0] iws,
                           logic perturb, logic dup);
    int w;
    w = int'(mem ? mws : iws) + ((mem && ram) ? 1 : 0);
    @(negedge clk_i);
    start_i = 1'b1; is_mem_i = mem; wr_i = wr; ram_sel_i = ram;
    mem_ws_i = mws; io_ws_i = iws;
    @(negedge clk_i);
    start_i = 1'b0;
    if (perturb) begin  // R9
      is_mem_i = ~mem; wr_i = ~wr; ram_sel_i = ~ram;
      mem_ws_i = ~mws; io_ws_i = ~iws;
    end
    for (int n = 1; n <= w + 1; n++) begin
      if (n > 1) @(negedge clk_i);
      if (dup) start_i = (n == 1);  // R8
      chk({req, " strobes"}, {29'd0, mem_rd_no, mem_wr_no, io_wr_no}, {29'd0, exp_stb(mem, wr)});
      chk({req, " R7 rdy"}, {31'd0, rdy_no}, {31'd0, n != w + 1});
      chk({req, " R5 start"}, {31'd0, cycle_start_o}, {31'd0, n == 1});
    end
    @(negedge clk_i);
    start_i = 1'b0;
    chk({req, " R6 idle"}, {28'd0, mem_rd_no, mem_wr_no, io_wr_no, rdy_no}, 32'hf);
    // R8: nothing follows a dropped start
    @(negedge clk_i);
    chk({req, " R8 no extra cycle"}, {28'd0, mem_rd_no, mem_wr_no, io_wr_no, rdy_no}, 32'hf);
  endtask

  task automatic t_mem_waits();
    for (int m = 0; m < 4; m++) run_cycle("R1 mem read", 1'b1, 1'b0, 1'b0, 2'(m), 2'(3 - m), 1'b0, 1'b0);
    run_cycle("R1 mem write", 1'b1, 1'b1, 1'b0, 2'd2, 2'd0, 1'b0, 1'b0);
  endtask

  task automatic t_io_waits();
    for (int m = 0; m < 4; m++) run_cycle("R2 io write", 1'b0, 1'b1, 1'b0, 2'(3 - m), 2'(m), 1'b0, 1'b0);
    run_cycle("R2 io read R4 none", 1'b0, 1'b0, 1'b0, 2'd3, 2'd1, 1'b0, 1'b0);
  endtask

  task automatic t_ram_extra();
    run_cycle("R3 ram read", 1'b1, 1'b0, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0);
    run_cycle("R3 ram write", 1'b1, 1'b1, 1'b1, 2'd3, 2'd0, 1'b0, 1'b0);
    run_cycle("R3 io ignores ram", 1'b0, 1'b1, 1'b1, 2'd0, 2'd1, 1'b0, 1'b0);
  endtask

  task automatic t_sampling();
    run_cycle("R9 held settings", 1'b1, 1'b0, 1'b0, 2'd1, 2'd3, 1'b1, 1'b0);
    run_cycle("R9 held settings io", 1'b0, 1'b1, 1'b0, 2'd3, 2'd2, 1'b1, 1'b0);
  endtask

  task automatic t_dup_start();
    run_cycle("R8 busy start", 1'b1, 1'b1, 1'b1, 2'd2, 2'd0, 1'b0, 1'b1);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    start_i = 1'b1; is_mem_i = 1'b1; wr_i = 1'b0; ram_sel_i = 1'b1; mem_ws_i = 2'd3;
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R10 reset mid-cycle", {27'd0, cycle_start_o, mem_rd_no, mem_wr_no, io_wr_no, rdy_no}, 32'hf);
    @(negedge clk_i);
    chk("R10 held in reset", {27'd0, cycle_start_o, mem_rd_no, mem_wr_no, io_wr_no, rdy_no}, 32'hf);
    rst_ni = 1'b1;
    run_cycle("R10 after reset", 1'b0, 1'b1, 1'b0, 2'd0, 2'd1, 1'b0, 1'b0);
  endtask

  initial begin
    #1;
    chk("R10 reset state", {27'd0, cycle_start_o, mem_rd_no, mem_wr_no, io_wr_no, rdy_no}, 32'hf);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_mem_waits();
    t_io_waits();
    t_ram_extra();
    t_sampling();
    t_dup_start();
    t_reset();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule